// File: doc/BRIEF.md
# I2C Master Register Controller

This block is the register-level front end of an I2C master. A processor-side port reaches five byte-wide registers: own address, clock divider, control, status and data. Accesses to these registers become byte-level bus operations (start with an address byte, send a byte, receive a byte, end the transfer). Each operation goes to a separate bit-level bus engine as a one-cycle command strobe. The engine answers with a done pulse, an acknowledge flag and a received byte.

The block remembers whether a target address is latched. The first data write in master mode with no address latched is taken as the address phase. Later data writes send bytes, and data reads in master mode trigger the next receive. A data read returns the byte captured by the previous read. The block also handles soft reset when the enable bit is cleared, master-mode entry and exit, and repeated start. It raises an interrupt line that software clears through the status register.

A register access is held on the port until `req_ready` is high. An access that needs the bus engine stalls until the engine reports completion.

Top module: `i2cm_regctl`

## Requirements
- R1: After reset every mapped register reads 0x00, including the data register's capture, and `irq` is low.
- R2: Writes keep only bits 7:0 of `req_wdata`. The own-address register keeps bits 7:1 (mask 0xFE), the divider keeps bits 5:0 (mask 0x3F), and control keeps bits 7:2 (mask 0xFC).
- R3: Writing control with bit 7 (enable) at 0 while enable is set is a soft reset. Divider, control, status, the data capture and the latched-address state return to reset; own address keeps its value. If an address was latched, an END command is issued.
- R4: Any other control write stores the masked value. Bit 5 (master) set makes status bit 5 (busy) read 1. Master clear makes busy read 0, and if an address was latched it is dropped and an END command is issued.
- R5: A control write leaving bit 2 (restart) set while an address is latched issues END and drops the address. The restart bit then reads back 0.
- R6: Status bit 1 (interrupt flag) clears only when a status write carries 0 in bit 1 while the flag is set, and `irq` then falls. Every other status bit ignores writes.
- R7: The interrupt flag and `irq` are set only when control bit 7 (enable) and bit 6 (interrupt enable) are both set.
- R8: A data write while enable is clear issues no command and changes no state.
- R9: In master mode with no address latched, a data write issues START carrying the byte (bits 7:1 address, bit 0 direction). On NACK, status bit 0 (received NACK) is set and nothing is latched. On ACK, the address is latched, bit 0 is cleared and an interrupt is raised.
- R10: With an address latched, a data write issues SEND. On ACK, bit 0 is cleared and an interrupt is raised. On NACK, bit 0 is set, the address is dropped and END is issued, so the next data write is a START.
- R11: A data read in master mode returns the byte captured by the previous read, then captures a new one. If an address is latched and control bit 4 (transmit) is clear, a RECV command supplies the new byte and an interrupt is raised. Otherwise the new byte is 0xFF, no command is issued and no interrupt is raised.
- R12: `cmd_valid` lasts exactly one cycle, with `cmd_op` START=0, SEND=1, RECV=2, END=3. An access that needs the engine keeps `req_ready` low until `eng_done`.
- R13: Registers sit at byte offsets 0x00 own address, 0x04 divider, 0x08 control, 0x0C status and 0x10 data. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data (bits 7:0 used) |
| req_ready | output | 1 | Access completes on this cycle |
| req_rdata | output | DATA_W | Read data, valid with req_ready |
| irq | output | 1 | Interrupt request, follows the status interrupt flag |
| cmd_valid | output | 1 | One-cycle command strobe to the bus engine |
| cmd_op | output | 2 | Command opcode: 0 START, 1 SEND, 2 RECV, 3 END |
| cmd_byte | output | 8 | Address byte for START, data byte for SEND |
| eng_done | input | 1 | Engine finished the current command |
| eng_ack | input | 1 | Target acknowledged (START and SEND) |
| eng_rx | input | 8 | Byte received (RECV) |

## Verification
Two events can land on the same register access. A SEND that gets a NACK both sets the received-NACK bit and drops the address, then chains an END before the access completes. A control write with restart set while an address is latched combines the master-mode update with the END and the self-clearing of restart. The bench provokes both with its engine model, which answers NACK for one chosen byte. It judges them by the opcode count the model logs, by status and control readback, and by checking that the next data write is a START.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_SEND  = 2'd1,
      OP_RECV  = 2'd2,
      OP_END   = 2'd3
   } eng_op_e;

   typedef enum logic [2:0] {
      SEL_OWN  = 3'd0,
      SEL_DIV  = 3'd1,
      SEL_CTRL = 3'd2,
      SEL_STAT = 3'd3,
      SEL_DATA = 3'd4,
      SEL_NONE = 3'd7
   } reg_sel_e;

   localparam int NUM_REGS = 5;

   // control bit positions
   localparam int CTL_EN   = 7;
   localparam int CTL_IEN  = 6;
   localparam int CTL_MST  = 5;
   localparam int CTL_TX   = 4;
   localparam int CTL_RSTA = 2;

   // status bit positions
   localparam int ST_BUSY  = 5;
   localparam int ST_IF    = 1;
   localparam int ST_NACK  = 0;

   localparam logic [7:0] OWN_MASK  = 8'hFE;
   localparam logic [7:0] DIV_MASK  = 8'h3F;
   localparam logic [7:0] CTL_MASK  = 8'hFC;
   localparam logic [7:0] RX_NOADDR = 8'hFF;

endpackage

// File: rtl/i2cm_decode.sv
module i2cm_decode
   import i2cm_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int STRIDE      = 4,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam int SHIFT = $clog2(STRIDE);

   if (STRIDE < 2 || (STRIDE & (STRIDE - 1)) != 0) begin : g_bad_stride
      $error("i2cm_decode: STRIDE must be a power of two >= 2");
   end
   if ((NUM_REGS - 1) * STRIDE >= (1 << ADDR_W)) begin : g_bad_width
      $error("i2cm_decode: ADDR_W too small for register map");
   end

   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] OFF = ADDR_W'(i * STRIDE);
      if (FULL_DECODE) begin : g_full
         assign hit[i] = (addr == OFF);
      end else begin : g_part
         assign hit[i] = (addr[ADDR_W-1:SHIFT] == OFF[ADDR_W-1:SHIFT]);
      end
   end

   if (!FULL_DECODE) begin : g_lo
      logic unused_lo;
      assign unused_lo = ^addr[SHIFT-1:0];
   end

   always_comb begin
      sel = SEL_NONE;
      for (int i = NUM_REGS - 1; i >= 0; i--) begin
         if (hit[i]) sel = reg_sel_e'(3'(i));
      end
   end

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic raise,
   input  logic wr_stat,
   input  logic wr_if_bit,
   input  logic busy_set,
   input  logic busy_clr,
   input  logic nack_set,
   input  logic nack_clr,
   output logic flag_if,
   output logic flag_busy,
   output logic flag_nack
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_if   <= 1'b0;
         flag_busy <= 1'b0;
         flag_nack <= 1'b0;
      end else if (soft_rst) begin
         flag_if   <= 1'b0;
         flag_busy <= 1'b0;
         flag_nack <= 1'b0;
      end else begin
         if (raise)
            flag_if <= 1'b1;
         else if (wr_stat && !wr_if_bit)
            flag_if <= 1'b0;

         if (busy_set)
            flag_busy <= 1'b1;
         else if (busy_clr)
            flag_busy <= 1'b0;

         if (nack_set)
            flag_nack <= 1'b1;
         else if (nack_clr)
            flag_nack <= 1'b0;
      end
   end

   a_r6_if_write_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_if && wr_stat && wr_if_bit && !soft_rst) |=> flag_if);

endmodule

// File: rtl/i2cm_regctl.sv
module i2cm_regctl
   import i2cm_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int REG_STRIDE  = 4,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] req_rdata,
   output logic              irq,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic [7:0]        cmd_byte,
   input  logic              eng_done,
   input  logic              eng_ack,
   input  logic [7:0]        eng_rx
);

   if (DATA_W < 8) begin : g_bad_data
      $error("i2cm_regctl: DATA_W must be at least 8");
   end

   localparam int PAD_W = DATA_W - 8;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_WOP  = 2'd1,
      S_WEND = 2'd2
   } state_e;

   // ------------------------------------------------------------------
   // register state
   // ------------------------------------------------------------------
   state_e     state_q, state_d;
   eng_op_e    pend_q;
   logic [7:0] own_q, div_q, ctl_q, rx_q;
   logic       addr_vld_q;
   eng_op_e    cmd_op_q;
   logic [7:0] cmd_byte_q;
   logic       cmd_valid_q;

   logic [7:0] wbyte;
   assign wbyte = req_wdata[7:0];

   if (DATA_W > 8) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^req_wdata[DATA_W-1:8];
   end

   reg_sel_e sel;

   i2cm_decode #(
      .ADDR_W      (ADDR_W),
      .STRIDE      (REG_STRIDE),
      .FULL_DECODE (FULL_DECODE)
   ) u_decode (
      .addr (req_addr),
      .sel  (sel)
   );

   // ------------------------------------------------------------------
   // access sequencing
   // ------------------------------------------------------------------
   logic       soft_rst, wr_own, wr_div, wr_ctl, wr_stat;
   logic       issue, raise_req, nack_set, nack_clr, busy_set, busy_clr;
   logic       addr_set, addr_clr, rx_load, need_end;
   eng_op_e    issue_op;
   logic [7:0] issue_byte, ctl_next, rx_val;
   logic       en, ien, mst;

   assign en  = ctl_q[CTL_EN];
   assign ien = ctl_q[CTL_IEN];
   assign mst = ctl_q[CTL_MST];

   always_comb begin
      state_d    = state_q;
      req_ready  = 1'b0;
      soft_rst   = 1'b0;
      wr_own     = 1'b0;
      wr_div     = 1'b0;
      wr_ctl     = 1'b0;
      wr_stat    = 1'b0;
      issue      = 1'b0;
      issue_op   = OP_END;
      issue_byte = 8'h00;
      raise_req  = 1'b0;
      nack_set   = 1'b0;
      nack_clr   = 1'b0;
      busy_set   = 1'b0;
      busy_clr   = 1'b0;
      addr_set   = 1'b0;
      addr_clr   = 1'b0;
      rx_load    = 1'b0;
      rx_val     = 8'h00;
      need_end   = 1'b0;
      ctl_next   = wbyte & CTL_MASK;

      unique case (state_q)
         S_IDLE: begin
            if (req_valid) begin
               if (req_write) begin
                  unique case (sel)
                     SEL_OWN: begin
                        wr_own    = 1'b1;
                        req_ready = 1'b1;
                     end
                     SEL_DIV: begin
                        wr_div    = 1'b1;
                        req_ready = 1'b1;
                     end
                     SEL_CTRL: begin
                        if (en && !wbyte[CTL_EN]) begin
                           soft_rst = 1'b1;
                           addr_clr = 1'b1;
                           need_end = addr_vld_q;
                        end else begin
                           wr_ctl = 1'b1;
                           if (ctl_next[CTL_MST]) begin
                              busy_set = 1'b1;
                              if (ctl_next[CTL_RSTA] && addr_vld_q) begin
                                 need_end           = 1'b1;
                                 addr_clr           = 1'b1;
                                 ctl_next[CTL_RSTA] = 1'b0;
                              end
                           end else begin
                              busy_clr = 1'b1;
                              if (addr_vld_q) begin
                                 need_end = 1'b1;
                                 addr_clr = 1'b1;
                              end
                           end
                        end
                        if (need_end) begin
                           issue    = 1'b1;
                           issue_op = OP_END;
                           state_d  = S_WEND;
                        end else begin
                           req_ready = 1'b1;
                        end
                     end
                     SEL_STAT: begin
                        wr_stat   = 1'b1;
                        req_ready = 1'b1;
                     end
                     SEL_DATA: begin
                        if (en && mst) begin
                           issue      = 1'b1;
                           issue_op   = addr_vld_q ? OP_SEND : OP_START;
                           issue_byte = wbyte;
                           state_d    = S_WOP;
                        end else begin
                           req_ready = 1'b1;
                        end
                     end
                     default: req_ready = 1'b1;
                  endcase
               end else begin
                  if (sel == SEL_DATA && mst) begin
                     if (!addr_vld_q || ctl_q[CTL_TX]) begin
                        rx_load   = 1'b1;
                        rx_val    = RX_NOADDR;
                        req_ready = 1'b1;
                     end else begin
                        issue    = 1'b1;
                        issue_op = OP_RECV;
                        state_d  = S_WOP;
                     end
                  end else begin
                     req_ready = 1'b1;
                  end
               end
            end
         end

         S_WOP: begin
            if (eng_done) begin
               unique case (pend_q)
                  OP_START: begin
                     if (eng_ack) begin
                        addr_set  = 1'b1;
                        nack_clr  = 1'b1;
                        raise_req = 1'b1;
                     end else begin
                        nack_set  = 1'b1;
                     end
                     req_ready = 1'b1;
                     state_d   = S_IDLE;
                  end
                  OP_SEND: begin
                     if (eng_ack) begin
                        nack_clr  = 1'b1;
                        raise_req = 1'b1;
                        req_ready = 1'b1;
                        state_d   = S_IDLE;
                     end else begin
                        nack_set = 1'b1;
                        addr_clr = 1'b1;
                        issue    = 1'b1;
                        issue_op = OP_END;
                        state_d  = S_WEND;
                     end
                  end
                  OP_RECV: begin
                     rx_load   = 1'b1;
                     rx_val    = eng_rx;
                     raise_req = 1'b1;
                     req_ready = 1'b1;
                     state_d   = S_IDLE;
                  end
                  default: begin
                     req_ready = 1'b1;
                     state_d   = S_IDLE;
                  end
               endcase
            end
         end

         S_WEND: begin
            if (eng_done) begin
               req_ready = 1'b1;
               state_d   = S_IDLE;
            end
         end

         default: state_d = S_IDLE;
      endcase
   end

   logic raise;
   assign raise = raise_req && en && ien;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         pend_q      <= OP_END;
         own_q       <= 8'h00;
         div_q       <= 8'h00;
         ctl_q       <= 8'h00;
         rx_q        <= 8'h00;
         addr_vld_q  <= 1'b0;
         cmd_valid_q <= 1'b0;
         cmd_op_q    <= OP_END;
         cmd_byte_q  <= 8'h00;
      end else begin
         state_q     <= state_d;
         cmd_valid_q <= issue;
         if (issue) begin
            pend_q     <= issue_op;
            cmd_op_q   <= issue_op;
            cmd_byte_q <= issue_byte;
         end
         if (wr_own) own_q <= wbyte & OWN_MASK;
         if (soft_rst) begin
            div_q <= 8'h00;
            ctl_q <= 8'h00;
            rx_q  <= 8'h00;
         end else begin
            if (wr_div)  div_q <= wbyte & DIV_MASK;
            if (wr_ctl)  ctl_q <= ctl_next;
            if (rx_load) rx_q  <= rx_val;
         end
         if (addr_clr)      addr_vld_q <= 1'b0;
         else if (addr_set) addr_vld_q <= 1'b1;
      end
   end

   // ------------------------------------------------------------------
   // status flags
   // ------------------------------------------------------------------
   logic flag_if, flag_busy, flag_nack;

   i2cm_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .raise     (raise),
      .wr_stat   (wr_stat),
      .wr_if_bit (wbyte[ST_IF]),
      .busy_set  (busy_set),
      .busy_clr  (busy_clr),
      .nack_set  (nack_set),
      .nack_clr  (nack_clr),
      .flag_if   (flag_if),
      .flag_busy (flag_busy),
      .flag_nack (flag_nack)
   );

   logic [7:0] stat_byte;
   always_comb begin
      stat_byte          = 8'h00;
      stat_byte[ST_BUSY] = flag_busy;
      stat_byte[ST_IF]   = flag_if;
      stat_byte[ST_NACK] = flag_nack;
   end

   // ------------------------------------------------------------------
   // outputs
   // ------------------------------------------------------------------
   logic [7:0] rd_byte;
   always_comb begin
      unique case (sel)
         SEL_OWN:  rd_byte = own_q;
         SEL_DIV:  rd_byte = div_q;
         SEL_CTRL: rd_byte = ctl_q;
         SEL_STAT: rd_byte = stat_byte;
         SEL_DATA: rd_byte = rx_q;
         default:  rd_byte = 8'h00;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign req_rdata = {{PAD_W{1'b0}}, rd_byte};
   end else begin : g_nopad
      assign req_rdata = rd_byte;
   end

   assign irq       = flag_if;
   assign cmd_valid = cmd_valid_q;
   assign cmd_op    = cmd_op_q;
   assign cmd_byte  = cmd_byte_q;

   // ------------------------------------------------------------------
   // assertions
   // ------------------------------------------------------------------
   a_r12_strobe_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   a_r12_ready_needs_req : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> req_valid);

   a_r7_irq_needs_enables : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(en && ien));

   a_r4_busy_follows_master : assert property (@(posedge clk) disable iff (!rst_n)
      flag_busy == mst);

   a_r9_latch_only_master : assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld_q |-> mst);

   a_r8_disabled_write_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && req_valid && req_write && sel == SEL_DATA && !en)
      |=> !cmd_valid);

endmodule

// File: tb/i2cm_regctl_tb.sv
`timescale 1ns/100ps
module i2cm_regctl_tb;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int LAT    = 3;

   localparam logic [7:0] A_OWN = 8'h00, A_DIV = 8'h04, A_CTL = 8'h08,
                          A_STA = 8'h0C, A_DAT = 8'h10, A_BAD = 8'h14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_ready;
   logic [DATA_W-1:0] req_rdata;
   logic              irq, cmd_valid;
   logic [1:0]        cmd_op;
   logic [7:0]        cmd_byte;
   logic              eng_done = 1'b0, eng_ack = 1'b0;
   logic [7:0]        eng_rx = 8'h00;

   always #2.5 clk = ~clk;

   i2cm_regctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .req_rdata(req_rdata), .irq(irq), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_byte(cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx));

   int checks = 0, errors = 0;
   int n_op [4];
   int bad_strobe = 0;
   logic [1:0] last_op;
   logic [7:0] last_byte;
   logic [7:0] rx_next = 8'h3C;
   logic [6:0] ack_target = 7'h50;
   logic [7:0] nack_byte  = 8'hEE;
   int cnt = 0;
   logic prev_cv = 1'b0;
   logic pend_ack;
   logic [7:0] pend_rx;
   int waited;

   // bus engine model
   always @(negedge clk) begin
      if (eng_done) eng_done = 1'b0;
      if (cnt > 0) begin
         cnt = cnt - 1;
         if (cnt == 0) begin
            eng_done = 1'b1;
            eng_ack  = pend_ack;
            eng_rx   = pend_rx;
         end
      end
      if (cmd_valid) begin
         if (prev_cv) bad_strobe++;
         n_op[cmd_op]++;
         last_op   = cmd_op;
         last_byte = cmd_byte;
         cnt       = LAT;
         pend_rx   = 8'h00;
         case (cmd_op)
            2'd0:    pend_ack = (cmd_byte[7:1] == ack_target);
            2'd1:    pend_ack = (cmd_byte != nack_byte);
            2'd2: begin pend_ack = 1'b1; pend_rx = rx_next; rx_next = rx_next + 8'h01; end
            default: pend_ack = 1'b1;
         endcase
      end
      prev_cv = cmd_valid;
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [7:0] a, input logic [15:0] d,
                      output logic [15:0] rd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      waited = 0;
      #1;
      while (!req_ready) begin
         @(negedge clk); #1;
         waited++;
      end
      rd = req_rdata;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      logic [15:0] dummy;
      acc(1'b1, a, d, dummy);
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] v);
      acc(1'b0, a, 16'h0, v);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(A_OWN, v); check("R1 own", v, 16'h00);
      rd(A_DIV, v); check("R1 div", v, 16'h00);
      rd(A_CTL, v); check("R1 ctrl", v, 16'h00);
      rd(A_STA, v); check("R1 status", v, 16'h00);
      rd(A_DAT, v); check("R1 data", v, 16'h00);
      check("R1 irq", {15'h0, irq}, 16'h0);
      rd(A_BAD, v); check("R13 unmapped read", v, 16'h00);
   endtask

   task automatic t_masks;
      logic [15:0] v;
      wr(A_OWN, 16'h1FF); rd(A_OWN, v); check("R2 own mask", v, 16'hFE);
      wr(A_DIV, 16'hFFFF); rd(A_DIV, v); check("R2 div mask", v, 16'h3F);
      wr(A_CTL, 16'h0103); rd(A_CTL, v); check("R2 ctrl mask", v, 16'h00);
      wr(A_BAD, 16'h00AA);
      rd(A_OWN, v); check("R13 unmapped write own", v, 16'hFE);
      rd(A_DIV, v); check("R13 unmapped write div", v, 16'h3F);
   endtask

   task automatic t_status_ro;
      logic [15:0] v;
      wr(A_STA, 16'hFF); rd(A_STA, v); check("R6 status ignores set", v, 16'h00);
   endtask

   task automatic t_disabled;
      logic [15:0] v;
      int s0;
      s0 = n_op[0] + n_op[1];
      wr(A_CTL, 16'h20); rd(A_STA, v); check("R4 busy on master", v, 16'h20);
      wr(A_DAT, 16'hA0);
      repeat (6) @(negedge clk);
      check("R8 no command when disabled", 16'(n_op[0] + n_op[1]), 16'(s0));
      wr(A_CTL, 16'h00); rd(A_STA, v); check("R4 busy off", v, 16'h00);
   endtask

   task automatic t_start;
      logic [15:0] v;
      wr(A_CTL, 16'hE0);
      wr(A_DAT, 16'h52);
      check("R9 start opcode", {14'h0, last_op}, 16'h0);
      check("R9 start byte", {8'h0, last_byte}, 16'h52);
      rd(A_STA, v); check("R9 nack status", v, 16'h21);
      check("R9 nack no irq", {15'h0, irq}, 16'h0);
      wr(A_DAT, 16'hA0);
      check("R9 retry is start", {14'h0, last_op}, 16'h0);
      check("R12 stall until done", 16'(waited >= LAT), 16'h1);
      rd(A_STA, v); check("R9 ack status", v, 16'h22);
      check("R9 ack irq", {15'h0, irq}, 16'h1);
      wr(A_STA, 16'hFF); rd(A_STA, v); check("R6 write 1 keeps flag", v, 16'h22);
      wr(A_STA, 16'hFD); rd(A_STA, v); check("R6 write 0 clears flag", v, 16'h20);
      check("R6 irq low", {15'h0, irq}, 16'h0);
   endtask

   task automatic t_send;
      logic [15:0] v;
      int e0;
      wr(A_DAT, 16'h33);
      check("R10 send opcode", {14'h0, last_op}, 16'h1);
      check("R10 send byte", {8'h0, last_byte}, 16'h33);
      check("R10 ack irq", {15'h0, irq}, 16'h1);
      wr(A_STA, 16'h00);
      e0 = n_op[3];
      wr(A_DAT, 16'hEE);
      check("R10 nack ends", 16'(n_op[3]), 16'(e0 + 1));
      rd(A_STA, v); check("R10 nack status", v, 16'h21);
      wr(A_DAT, 16'hA0);
      check("R10 next write is start", {14'h0, last_op}, 16'h0);
      wr(A_STA, 16'h00);
   endtask

   task automatic t_restart;
      logic [15:0] v;
      int e0;
      e0 = n_op[3];
      wr(A_CTL, 16'hE4);
      check("R5 restart ends", 16'(n_op[3]), 16'(e0 + 1));
      rd(A_CTL, v); check("R5 restart self clears", v, 16'hE0);
      wr(A_DAT, 16'hA0);
      check("R5 next write is start", {14'h0, last_op}, 16'h0);
      wr(A_STA, 16'h00);
   endtask

   task automatic t_master_exit;
      logic [15:0] v;
      int e0;
      e0 = n_op[3];
      wr(A_CTL, 16'hC0);
      check("R4 exit ends", 16'(n_op[3]), 16'(e0 + 1));
      rd(A_STA, v); check("R4 exit busy clear", v, 16'h00);
      wr(A_CTL, 16'hE0);
      wr(A_DAT, 16'hA0);
      check("R4 re-entry start", {14'h0, last_op}, 16'h0);
      wr(A_STA, 16'h00);
   endtask

   task automatic t_read;
      logic [15:0] v;
      int r0;
      wr(A_CTL, 16'h00);
      wr(A_CTL, 16'hE0);
      r0 = n_op[2];
      rd(A_DAT, v); check("R11 first read old capture", v, 16'h00);
      rd(A_DAT, v); check("R11 no address gives FF", v, 16'hFF);
      check("R11 no recv without address", 16'(n_op[2]), 16'(r0));
      check("R11 no irq without recv", {15'h0, irq}, 16'h0);
      wr(A_DAT, 16'hA1); wr(A_STA, 16'h00);
      rd(A_DAT, v); check("R11 returns prior capture", v, 16'hFF);
      check("R11 recv opcode", {14'h0, last_op}, 16'h2);
      check("R11 recv irq", {15'h0, irq}, 16'h1);
      wr(A_STA, 16'h00);
      rd(A_DAT, v); check("R11 first received byte", v, 16'h3C);
      wr(A_STA, 16'h00);
      wr(A_CTL, 16'hF0);
      r0 = n_op[2];
      rd(A_DAT, v); check("R11 second received byte", v, 16'h3D);
      rd(A_DAT, v); check("R11 tx bit gives FF", v, 16'hFF);
      check("R11 tx bit no recv", 16'(n_op[2]), 16'(r0));
      check("R11 tx bit no irq", {15'h0, irq}, 16'h0);
   endtask

   task automatic t_irq_gate;
      logic [15:0] v;
      wr(A_CTL, 16'h00);
      wr(A_CTL, 16'hA0);
      wr(A_DAT, 16'hA0);
      rd(A_STA, v); check("R7 no flag without irq enable", v, 16'h20);
      check("R7 irq low", {15'h0, irq}, 16'h0);
   endtask

   task automatic t_soft_reset;
      logic [15:0] v;
      int e0;
      wr(A_OWN, 16'h5A); wr(A_DIV, 16'h12);
      e0 = n_op[3];
      wr(A_CTL, 16'h00);
      check("R3 end on soft reset", 16'(n_op[3]), 16'(e0 + 1));
      rd(A_OWN, v); check("R3 own kept", v, 16'h5A);
      rd(A_DIV, v); check("R3 div reset", v, 16'h00);
      rd(A_CTL, v); check("R3 ctrl reset", v, 16'h00);
      rd(A_STA, v); check("R3 status reset", v, 16'h00);
   endtask

   logic done_flag = 1'b0;

   initial begin
      n_op = '{default: 0};
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_masks();
      t_status_ro();
      t_disabled();
      t_start();
      t_send();
      t_restart();
      t_master_exit();
      t_read();
      t_irq_gate();
      t_soft_reset();
      check("R12 strobe one cycle", 16'(bad_strobe), 16'h0);
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule